// File: doc/BRIEF.md
# Predicated Execute Unit

This block is a single-cycle execute stage built around a sixteen-entry, 32-bit register file. Each cycle in which the valid strobe is high, it accepts one 32-bit instruction. It reads the source registers, runs a simple operation and writes the result back at the next clock edge. A 4-bit condition field in the top nibble gates every instruction. The field is tested against relation flags, and only a compare instruction sets those flags. A loop that holds a data-dependent decision can therefore run as a straight sequence of instructions, with no branches.

Two instruction formats share the upper 20 bits. From bit 31 down they hold the condition, the opcode, the first source rs and the destination rd. In the register format the low 12 bits hold an 8-bit auxiliary field and then the second source rt. In the immediate format the low 12 bits hold a 12-bit immediate. One opcode adds rs to rt shifted left by an amount taken from the auxiliary field, which gives a scaled add in one instruction. A separate combinational read port lets the surrounding logic, or a bench, observe any register.

Top module: `cond_exec_unit`

## Requirements
- R1: After reset every register reads zero and the flags hold the "equal" relation, so condition EQ passes and NE fails.
- R2: Fields sit at fixed positions: cond [31:28], opcode [27:20], rs [19:16], rd [15:12], auxiliary [11:4], rt [3:0], immediate [11:0].
- R3: Opcode 0x01 writes rd = rs + rt and opcode 0x02 writes rd = rs - rt, both modulo 2^32.
- R4: Opcodes 0x11 (rd = rs + imm), 0x12 (rd = rs - imm) and 0x13 (rd = imm) use the 12-bit immediate zero-extended to 32 bits.
- R5: Opcode 0x03 writes rd = rs + (rt << s), where s is bits [8:4] of the instruction (the low 5 bits of the auxiliary field); the upper auxiliary bits are ignored.
- R6: Opcode 0x04 (rs against rt) and opcode 0x14 (rs against the immediate) compare as signed 32-bit values, set exactly one of equal, less and greater, and write no register.
- R7: Condition codes are 0 EQ, 1 NE, 2 LT, 3 GT, 4 LE (not greater), 5 GE (not less) and 14 always; the codes 6 to 13 and 15 never execute.
- R8: An instruction whose condition fails changes no register and no flag.
- R9: Only an executed compare changes the flags; arithmetic and move instructions leave them as they were.
- R10: While valid is low, the instruction input has no effect.
- R11: A register write takes effect at the clock edge, so the read port and an instruction issued in the next cycle both see the new value.
- R12: An opcode outside the listed set changes no register and no flag.
- R13: Repeating compare rs,rt; GT subtract rs = rs - rt; LE subtract rt = rt - rs on two positive values leaves their greatest common divisor in rs and zero in rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| chk_addr_i | input | 4 | Observation port register index |
| chk_data_o | output | 32 | Observation port register value |

## Verification
The arithmetic opcodes are driven with carry-out and borrow operands and with a 12-bit immediate that has its top bit set. These cases show whether results wrap and whether the immediate is zero- or sign-extended. The compare is given -1 against 5, so a signed relation can be told apart from an unsigned one. After each flag state, every condition code is probed, which shows whether the codes are decoded correctly and whether the flags stay put across failed, non-compare, unknown and invalid instructions. The shift-add is given a shift of zero, one of 31 and an auxiliary field with its upper bits set. Two GCD runs confirm the branch-free convergence, and a back-to-back issue pair exposes any stale read of a register just written.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned IMM_W   = 12;
  localparam int unsigned SHAM_W  = 5;

  localparam logic [7:0] OP_ADD   = 8'h01;
  localparam logic [7:0] OP_SUB   = 8'h02;
  localparam logic [7:0] OP_SHADD = 8'h03;
  localparam logic [7:0] OP_CMP   = 8'h04;
  localparam logic [7:0] OP_ADDI  = 8'h11;
  localparam logic [7:0] OP_SUBI  = 8'h12;
  localparam logic [7:0] OP_MOVI  = 8'h13;
  localparam logic [7:0] OP_CMPI  = 8'h14;

  typedef enum logic [3:0] {
    C_EQ = 4'h0, C_NE = 4'h1, C_LT = 4'h2, C_GT = 4'h3,
    C_LE = 4'h4, C_GE = 4'h5, C_AL = 4'hE
  } cond_e;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_SHADD, K_MOV, K_CMP
  } kind_e;

  typedef struct packed {
    logic eq;
    logic lt;
    logic gt;
  } flags_t;

  typedef struct packed {
    logic [3:0]        cond;
    kind_e             kind;
    logic              use_imm;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rt;
    logic [SHAM_W-1:0] shamt;
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [7:0] op;
  assign op = instr_i[27:20];

  always_comb begin
    dec_o.cond    = instr_i[31:28];
    dec_o.rs      = instr_i[19:16];
    dec_o.rd      = instr_i[15:12];
    dec_o.rt      = instr_i[3:0];
    dec_o.shamt   = instr_i[4+SHAM_W-1:4];
    dec_o.imm     = instr_i[IMM_W-1:0];
    dec_o.use_imm = 1'b0;
    dec_o.kind    = K_NOP;
    case (op)
      OP_ADD:   dec_o.kind = K_ADD;
      OP_SUB:   dec_o.kind = K_SUB;
      OP_SHADD: dec_o.kind = K_SHADD;
      OP_CMP:   dec_o.kind = K_CMP;
      OP_ADDI:  begin dec_o.kind = K_ADD; dec_o.use_imm = 1'b1; end
      OP_SUBI:  begin dec_o.kind = K_SUB; dec_o.use_imm = 1'b1; end
      OP_MOVI:  begin dec_o.kind = K_MOV; dec_o.use_imm = 1'b1; end
      OP_CMPI:  begin dec_o.kind = K_CMP; dec_o.use_imm = 1'b1; end
      default:  dec_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/cx_cond_eval.sv
module cx_cond_eval
  import cx_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  always_comb begin
    case (cond_i)
      C_EQ:    pass_o = flags_i.eq;
      C_NE:    pass_o = !flags_i.eq;
      C_LT:    pass_o = flags_i.lt;
      C_GT:    pass_o = flags_i.gt;
      C_LE:    pass_o = !flags_i.gt;
      C_GE:    pass_o = !flags_i.lt;
      C_AL:    pass_o = 1'b1;
      default: pass_o = 1'b0; // reserved codes never execute
    endcase
  end
endmodule

// File: rtl/cx_alu.sv
module cx_alu
  import cx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  kind_e             kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SHAM_W-1:0] shamt_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  always_comb begin
    case (kind_i)
      K_ADD:   res_o = a_i + b_i;
      K_SUB:   res_o = a_i - b_i;
      K_SHADD: res_o = a_i + (b_i << shamt_i);
      K_MOV:   res_o = b_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    flags_o.eq = (a_i == b_i);
    flags_o.lt = ($signed(a_i) < $signed(b_i));
    flags_o.gt = !flags_o.eq && !flags_o.lt;
  end
endmodule

// File: rtl/cx_regfile.sv
module cx_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 16,
  parameter int unsigned NRP    = 3,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NRP-1:0][AW-1:0]     raddr_i,
  output logic [NRP-1:0][DATA_W-1:0] rdata_o
);
  logic [NREGS-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
  import cx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 16,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AW-1:0]      chk_addr_i,
  output logic [DATA_W-1:0]  chk_data_o
);
  localparam int unsigned NRP = 3;

  dec_t                      dec;
  flags_t                    flags_q, flags_nx;
  logic                      cond_pass, fire, wr_en, flag_we, is_cmp;
  logic [NRP-1:0][AW-1:0]    raddr;
  logic [NRP-1:0][DATA_W-1:0] rdata;
  logic [DATA_W-1:0]         op_b, alu_res;

  cx_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  cx_cond_eval u_cond (.cond_i(dec.cond), .flags_i(flags_q), .pass_o(cond_pass));

  assign raddr = {chk_addr_i, dec.rt, dec.rs};

  cx_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .NRP(NRP)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (dec.rd),
    .wdata_i (alu_res),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign op_b = dec.use_imm ? {{(DATA_W-IMM_W){1'b0}}, dec.imm} : rdata[1];

  cx_alu #(.DATA_W(DATA_W)) u_alu (
    .kind_i  (dec.kind),
    .a_i     (rdata[0]),
    .b_i     (op_b),
    .shamt_i (dec.shamt),
    .res_o   (alu_res),
    .flags_o (flags_nx)
  );

  assign is_cmp  = (dec.kind == K_CMP);
  assign fire    = valid_i && cond_pass;
  assign flag_we = fire && is_cmp;
  assign wr_en   = fire && !is_cmp && (dec.kind != K_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '{eq: 1'b1, lt: 1'b0, gt: 1'b0};
    end else if (flag_we) begin
      flags_q <= flags_nx;
    end
  end

  assign chk_data_o = rdata[2];
endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk
  import cx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              cond_pass,
  input logic              wr_en,
  input logic              flag_we,
  input logic              is_cmp,
  input flags_t            flags_q,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [AW-1:0]     chk_addr_i,
  input logic [DATA_W-1:0] chk_data_o
);
  AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(flags_q)); // R6

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmp |-> !wr_en); // R6

  AST_FAIL_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass) |-> (!wr_en && !flag_we)); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we |=> $stable(flags_q)); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_en && !flag_we)); // R10

  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == chk_addr_i) |=>
      (!$stable(chk_addr_i) || chk_data_o == $past(wr_data))); // R11
endmodule

bind cond_exec_unit cond_exec_unit_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .cond_pass  (cond_pass),
  .wr_en      (wr_en),
  .flag_we    (flag_we),
  .is_cmp     (is_cmp),
  .flags_q    (flags_q),
  .wr_addr    (dec.rd),
  .wr_data    (alu_res),
  .chk_addr_i (chk_addr_i),
  .chk_data_o (chk_data_o)
);

// File: tb/cond_exec_unit_tb_top.sv
`timescale 1ns/1ps
module cond_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [3:0]  chk_addr_i = '0;
  logic [31:0] chk_data_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [3:0] EQ = 4'h0, NE = 4'h1, LT = 4'h2, GT = 4'h3,
                         LE = 4'h4, GE = 4'h5, AL = 4'hE;

  always #4 clk_i = ~clk_i; // 125 MHz

  cond_exec_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .instr_i(instr_i), .chk_addr_i(chk_addr_i), .chk_data_o(chk_data_o)
  );

  function automatic logic [31:0] rr(logic [3:0] c, logic [7:0] op, logic [3:0] rs,
                                     logic [3:0] rd, logic [7:0] x, logic [3:0] rt);
    return {c, op, rs, rd, x, rt};
  endfunction

  function automatic logic [31:0] ri(logic [3:0] c, logic [7:0] op, logic [3:0] rs,
                                     logic [3:0] rd, logic [11:0] imm);
    return {c, op, rs, rd, imm};
  endfunction

  task automatic chk(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    chk_addr_i = idx;
    #1;
    n_chk++;
    if (chk_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s: r%0d actual=%h expected=%h", tag, idx, chk_data_o, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins);
    @(negedge clk_i);
    instr_i = ins;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // r13 is the probe register
  task automatic probe(input logic [3:0] c, input bit exp_pass, input string tag);
    issue(ri(AL, 8'h13, 4'h0, 4'd13, 12'h000));
    issue(ri(c, 8'h13, 4'h0, 4'd13, 12'h077));
    chk(4'd13, exp_pass ? 32'h77 : 32'h0, tag);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) chk(4'(i), 32'h0, "R1 reset register");
    probe(EQ, 1'b1, "R1 EQ after reset");
    probe(NE, 1'b0, "R1 NE after reset");
  endtask

  task automatic t_imm();
    issue(ri(AL, 8'h13, 4'd7, 4'd3, 12'hFFF));
    chk(4'd3, 32'h0000_0FFF, "R4 move imm zero-extended");
    issue(ri(AL, 8'h11, 4'd3, 4'd4, 12'h001));
    chk(4'd4, 32'h0000_1000, "R4 add imm");
    issue(ri(AL, 8'h12, 4'd0, 4'd5, 12'h001));
    chk(4'd5, 32'hFFFF_FFFF, "R4 sub imm wraps");
  endtask

  task automatic t_rr();
    issue(rr(AL, 8'h01, 4'd3, 4'd6, 8'h00, 4'd4));
    chk(4'd6, 32'h0000_1FFF, "R3 add reg");
    issue(rr(AL, 8'h02, 4'd3, 4'd7, 8'h00, 4'd4));
    chk(4'd7, 32'hFFFF_FFFF, "R3 sub reg borrow");
    issue(rr(AL, 8'h01, 4'd5, 4'd8, 8'h00, 4'd5));
    chk(4'd8, 32'hFFFF_FFFE, "R3 add reg carry out dropped (R2 fields)");
  endtask

  task automatic t_shadd();
    issue(ri(AL, 8'h13, 4'd0, 4'd1, 12'd5));
    issue(rr(AL, 8'h03, 4'd1, 4'd9, 8'h04, 4'd1));
    chk(4'd9, 32'd85, "R5 shift-add by 4");
    issue(rr(AL, 8'h03, 4'd0, 4'd10, 8'h1F, 4'd1));
    chk(4'd10, 32'h8000_0000, "R5 shift-add by 31");
    issue(rr(AL, 8'h03, 4'd0, 4'd11, 8'hE4, 4'd3));
    chk(4'd11, 32'h0000_FFF0, "R5 upper aux bits ignored");
    issue(rr(AL, 8'h03, 4'd1, 4'd11, 8'h00, 4'd1));
    chk(4'd11, 32'd10, "R5 shift-add by 0");
  endtask

  task automatic t_cmp();
    issue(ri(AL, 8'h13, 4'd0, 4'd12, 12'h055));
    issue(rr(AL, 8'h04, 4'd5, 4'd12, 8'h00, 4'd1)); // -1 vs 5
    chk(4'd12, 32'h55, "R6 compare writes no register");
    probe(LT, 1'b1, "R6 signed -1<5 LT");
    probe(GT, 1'b0, "R7 GT fails on less");
    probe(LE, 1'b1, "R7 LE passes on less");
    probe(GE, 1'b0, "R7 GE fails on less");
    probe(NE, 1'b1, "R7 NE passes on less");
    probe(EQ, 1'b0, "R7 EQ fails on less");
    issue(ri(AL, 8'h14, 4'd1, 4'd0, 12'd5));
    probe(EQ, 1'b1, "R6 compare imm equal");
    probe(GE, 1'b1, "R7 GE passes on equal");
    probe(LE, 1'b1, "R7 LE passes on equal");
    issue(rr(AL, 8'h04, 4'd1, 4'd0, 8'h00, 4'd5)); // 5 vs -1
    probe(GT, 1'b1, "R6 signed 5>-1 GT");
    probe(LE, 1'b0, "R7 LE fails on greater");
  endtask

  task automatic t_never();
    probe(4'h7, 1'b0, "R7 reserved code 7");
    probe(4'hF, 1'b0, "R7 reserved code 15");
  endtask

  task automatic t_cond_fail();
    issue(rr(LT, 8'h04, 4'd5, 4'd0, 8'h00, 4'd1));
    probe(GT, 1'b1, "R8 failed compare keeps flags");
    issue(rr(LT, 8'h02, 4'd3, 4'd12, 8'h00, 4'd4));
    chk(4'd12, 32'h55, "R8 failed subtract no write");
  endtask

  task automatic t_flags();
    issue(rr(AL, 8'h01, 4'd6, 4'd6, 8'h00, 4'd6));
    chk(4'd6, 32'h0000_3FFE, "R9 add executes");
    probe(GT, 1'b1, "R9 add leaves flags");
  endtask

  task automatic t_valid();
    @(negedge clk_i);
    instr_i = ri(AL, 8'h13, 4'd0, 4'd14, 12'h099);
    repeat (3) @(negedge clk_i);
    chk(4'd14, 32'h0, "R10 invalid move ignored");
    instr_i = ri(AL, 8'h14, 4'd0, 4'd0, 12'h000);
    repeat (3) @(negedge clk_i);
    probe(GT, 1'b1, "R10 invalid compare ignored");
  endtask

  task automatic t_raw();
    @(negedge clk_i);
    instr_i = ri(AL, 8'h13, 4'd0, 4'd15, 12'd3);
    valid_i = 1'b1;
    @(negedge clk_i);
    chk(4'd15, 32'd3, "R11 read port after edge");
    instr_i = ri(AL, 8'h11, 4'd15, 4'd15, 12'd4);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(4'd15, 32'd7, "R11 back-to-back read of new value");
  endtask

  task automatic t_unknown();
    issue(ri(AL, 8'hAA, 4'd15, 4'd14, 12'h123));
    chk(4'd14, 32'h0, "R12 unknown opcode no write");
    issue(rr(AL, 8'h24, 4'd0, 4'd14, 8'h00, 4'd0));
    probe(GT, 1'b1, "R12 unknown opcode keeps flags");
  endtask

  task automatic gcd_run(input logic [11:0] a, input logic [11:0] b, input logic [31:0] g);
    issue(ri(AL, 8'h13, 4'd0, 4'd8, a));
    issue(ri(AL, 8'h13, 4'd0, 4'd9, b));
    for (int i = 0; i < 24; i++) begin
      issue(rr(AL, 8'h04, 4'd8, 4'd0, 8'h00, 4'd9));
      issue(rr(GT, 8'h02, 4'd8, 4'd8, 8'h00, 4'd9));
      issue(rr(LE, 8'h02, 4'd9, 4'd9, 8'h00, 4'd8));
    end
    chk(4'd8, g, "R13 gcd in rs");
    chk(4'd9, 32'h0, "R13 rt cleared");
  endtask

  task automatic t_gcd();
    gcd_run(12'd84, 12'd36, 32'd12);
    gcd_run(12'd17, 12'd5, 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_imm();
    t_rr();
    t_shadd();
    t_cmp();
    t_never();
    t_cond_fail();
    t_flags();
    t_valid();
    t_raw();
    t_unknown();
    t_gcd();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule